// File: doc/BRIEF.md
# Byte Command Decoder for Pulse Control

This block sits between a serial byte receiver and a triggered pulse generator. It reads single-letter commands from the incoming byte stream and acts on them. Three commands load 32-bit parameters: a trigger edge count, a pulse offset and a pulse width. Each takes a four-byte operand, sent least significant byte first. Other commands arm the generator, wait for it to finish (with a way to abort the wait), drive a target reset line, and read back status.

Arming works in this order. The stored parameters are copied to the generator, the target reset line is released, and the block waits a settle delay (tens of milliseconds at the system clock) before it enables the generator. Every command that the block accepts returns a short reply of raw bytes on a valid/ready transmit port. Values in a reply go least significant byte first, and every reply ends with a newline byte (0x0A).

Top module: `pulse_cmd_decoder`

## Requirements
- R1: 'E' (0x45), 'O' (0x4F) and 'W' (0x57) each take four operand bytes, least significant first, and load the edge count, offset and width respectively. The reply is the loaded value as four bytes LSB first, then 0x0A.
- R2: After reset the edge count is 1 and the offset and width are 0.
- R3: 'A' (0x41) copies edge count, offset and width onto gen_edges, gen_offset and gen_width, and drives target_run to 1 on the same edge. gen_enable rises exactly SETTLE_CYCLES cycles later, and then the reply 'A' 0x0A is sent.
- R4: 'B' (0x42) waits until gen_done is 1 or the byte 'D' (0x44) arrives; any other byte leaves the wait running. When the wait ends, gen_enable goes to 0, gen_rearm pulses for exactly one cycle, and the reply 'T' 0x0A is sent.
- R5: 'G' (0x47) takes a pin byte and then a state byte. Only pin RST_PIN_ID (7) has an effect: target_run becomes 0 if the state byte is zero and 1 otherwise. The reply is 'G' 0x0A for any pin.
- R6: 'S' (0x53) replies with offset, width and edge count, each four bytes LSB first in that order, then 0x0A (13 bytes in all).
- R7: 'R' (0x52) replies with io_state as four bytes LSB first, then 0x0A.
- R8: After reset, target_run, gen_enable and tx_valid are 0. A byte that is not a command produces no reply and changes nothing.
- R9: If no operand byte arrives for BYTE_TIMEOUT cycles, the partial operand is discarded, the parameter keeps its old value, and parsing restarts at idle with no reply. Gaps shorter than the timeout are accepted.
- R10: While tx_valid is 1 and tx_ready is 0, tx_data holds its value. Reply bytes advance only when the receiver accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the reply byte |
| gen_edges | output | PARAM_W | Edge count handed to the generator |
| gen_offset | output | PARAM_W | Offset handed to the generator |
| gen_width | output | PARAM_W | Width handed to the generator |
| gen_enable | output | 1 | Generator run enable |
| gen_rearm | output | 1 | One-cycle clear of done flag and return to entry state |
| gen_done | input | 1 | Generator finished its pulse |
| target_run | output | 1 | Target reset line, 1 = released |
| io_state | input | IO_W | Pin state snapshot for the 'R' reply |

## Verification
The bench builds the block with SETTLE_CYCLES = 40 and BYTE_TIMEOUT = 16. With these values the exact arm-to-enable interval can be counted cycle by cycle, and an operand gap either inside or past the timeout is a matter of a few dozen cycles. The real settle delay is millions of cycles, so these short values are what make the arm sequence and the timeout-discard path reachable in a directed run. Back-pressure on the transmit side is applied during a 13-byte status reply.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPND, ST_GPIN, ST_GVAL, ST_SETTLE, ST_WAIT, ST_REPLY
  } pcd_state_e;

  typedef enum logic [1:0] {SEL_EDGE, SEL_OFS, SEL_WID} pcd_sel_e;

  localparam logic [7:0] CH_E  = 8'h45;
  localparam logic [7:0] CH_O  = 8'h4F;
  localparam logic [7:0] CH_W  = 8'h57;
  localparam logic [7:0] CH_A  = 8'h41;
  localparam logic [7:0] CH_B  = 8'h42;
  localparam logic [7:0] CH_D  = 8'h44;
  localparam logic [7:0] CH_G  = 8'h47;
  localparam logic [7:0] CH_R  = 8'h52;
  localparam logic [7:0] CH_S  = 8'h53;
  localparam logic [7:0] CH_T  = 8'h54;
  localparam logic [7:0] CH_NL = 8'h0A;
endpackage

// File: rtl/cmd_countdown.sv
module cmd_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/reply_shifter.sv
module reply_shifter #(
  parameter int MAX_BYTES = 13,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [LEN_W-1:0]       load_len,
  input  logic [MAX_BYTES*8-1:0] load_data,
  input  logic                   tx_ready,
  output logic                   tx_valid,
  output logic [7:0]             tx_data,
  output logic                   busy
);
  logic [MAX_BYTES*8-1:0] sh;
  logic [LEN_W-1:0]       left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= load_data;
      left <= load_len;
    end else if (left != '0 && tx_ready) begin
      sh   <= sh >> 8;
      left <= left - 1'b1;
    end
  end

  assign tx_valid = (left != '0);
  assign tx_data  = sh[7:0];
  assign busy     = tx_valid;
endmodule

// File: rtl/pulse_cmd_decoder.sv
module pulse_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int PARAM_W       = 32,
  parameter int IO_W          = 32,
  parameter int SETTLE_CYCLES = 5_750_000,
  parameter int BYTE_TIMEOUT  = 1_250_000,
  parameter int RST_PIN_ID    = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  input  logic               tx_ready,
  output logic [PARAM_W-1:0] gen_edges,
  output logic [PARAM_W-1:0] gen_offset,
  output logic [PARAM_W-1:0] gen_width,
  output logic               gen_enable,
  output logic               gen_rearm,
  input  logic               gen_done,
  output logic               target_run,
  input  logic [IO_W-1:0]    io_state
);
  localparam int OPND_BYTES  = PARAM_W / 8;
  localparam int IDX_W       = $clog2(OPND_BYTES);
  localparam int REPLY_BYTES = 3 * OPND_BYTES + 1;
  localparam int RPW         = REPLY_BYTES * 8;
  localparam int LEN_W       = $clog2(REPLY_BYTES + 1);
  localparam int TMR_MAX     = (SETTLE_CYCLES > BYTE_TIMEOUT) ? SETTLE_CYCLES : BYTE_TIMEOUT;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);

  pcd_state_e         state;
  pcd_sel_e           sel;
  logic [IDX_W-1:0]   idx;
  logic [PARAM_W-1:0] opnd_sh, opnd_next;
  logic [7:0]         pin_q;
  logic [PARAM_W-1:0] edges_q, ofs_q, wid_q;
  logic               rp_load, rp_busy;
  logic [LEN_W-1:0]   rp_len;
  logic [RPW-1:0]     rp_data;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;
  logic               is_param_cmd;

  function automatic logic [RPW-1:0] pack_chr(input logic [7:0] c);
    logic [RPW-1:0] r;
    r = '0;
    r[7:0]  = c;
    r[15:8] = CH_NL;
    return r;
  endfunction

  function automatic logic [RPW-1:0] pack_val(input logic [PARAM_W-1:0] v);
    logic [RPW-1:0] r;
    r = '0;
    r[PARAM_W-1:0]    = v;
    r[PARAM_W +: 8]   = CH_NL;
    return r;
  endfunction

  assign opnd_next    = {rx_data, opnd_sh[PARAM_W-1:8]};
  assign is_param_cmd = (rx_data == CH_E) || (rx_data == CH_O) || (rx_data == CH_W);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(BYTE_TIMEOUT - 1);
    if (rx_valid) begin
      if (state == ST_IDLE) begin
        tmr_load = is_param_cmd || (rx_data == CH_G) || (rx_data == CH_A);
        if (rx_data == CH_A) tmr_val = TMR_W'(SETTLE_CYCLES - 1);
      end else if (state == ST_OPND || state == ST_GPIN) begin
        tmr_load = 1'b1;
      end
    end
  end

  cmd_countdown #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  reply_shifter #(.MAX_BYTES(REPLY_BYTES)) u_reply (
    .clk(clk), .rst(rst), .load(rp_load), .load_len(rp_len), .load_data(rp_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(rp_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sel        <= SEL_EDGE;
      idx        <= '0;
      opnd_sh    <= '0;
      pin_q      <= '0;
      edges_q    <= PARAM_W'(1);
      ofs_q      <= '0;
      wid_q      <= '0;
      gen_edges  <= '0;
      gen_offset <= '0;
      gen_width  <= '0;
      gen_enable <= 1'b0;
      gen_rearm  <= 1'b0;
      target_run <= 1'b0;
      rp_load    <= 1'b0;
      rp_len     <= '0;
      rp_data    <= '0;
    end else begin
      rp_load   <= 1'b0;
      gen_rearm <= 1'b0;
      case (state)
        ST_IDLE: if (rx_valid) begin
          idx <= '0;
          if (is_param_cmd) begin
            sel   <= (rx_data == CH_E) ? SEL_EDGE : (rx_data == CH_O) ? SEL_OFS : SEL_WID;
            state <= ST_OPND;
          end else if (rx_data == CH_G) begin
            state <= ST_GPIN;
          end else if (rx_data == CH_A) begin
            gen_edges  <= edges_q;
            gen_offset <= ofs_q;
            gen_width  <= wid_q;
            target_run <= 1'b1;
            state      <= ST_SETTLE;
          end else if (rx_data == CH_B) begin
            state <= ST_WAIT;
          end else if (rx_data == CH_R) begin
            rp_data <= '0;
            rp_data[IO_W-1:0]  <= io_state;
            rp_data[IO_W +: 8] <= CH_NL;
            rp_len  <= LEN_W'(IO_W / 8 + 1);
            rp_load <= 1'b1;
            state   <= ST_REPLY;
          end else if (rx_data == CH_S) begin
            rp_data <= {CH_NL, edges_q, wid_q, ofs_q};
            rp_len  <= LEN_W'(REPLY_BYTES);
            rp_load <= 1'b1;
            state   <= ST_REPLY;
          end
        end
        ST_OPND: begin
          if (rx_valid) begin
            opnd_sh <= opnd_next;
            idx     <= idx + 1'b1;
            if (idx == IDX_W'(OPND_BYTES - 1)) begin
              case (sel)
                SEL_EDGE: edges_q <= opnd_next;
                SEL_OFS:  ofs_q   <= opnd_next;
                default:  wid_q   <= opnd_next;
              endcase
              rp_data <= pack_val(opnd_next);
              rp_len  <= LEN_W'(OPND_BYTES + 1);
              rp_load <= 1'b1;
              state   <= ST_REPLY;
            end
          end else if (tmr_zero) begin
            state <= ST_IDLE;
          end
        end
        ST_GPIN: begin
          if (rx_valid) begin
            pin_q <= rx_data;
            state <= ST_GVAL;
          end else if (tmr_zero) begin
            state <= ST_IDLE;
          end
        end
        ST_GVAL: begin
          if (rx_valid) begin
            if (pin_q == 8'(RST_PIN_ID)) target_run <= (rx_data != 8'h00);
            rp_data <= pack_chr(CH_G);
            rp_len  <= LEN_W'(2);
            rp_load <= 1'b1;
            state   <= ST_REPLY;
          end else if (tmr_zero) begin
            state <= ST_IDLE;
          end
        end
        ST_SETTLE: if (tmr_zero) begin
          gen_enable <= 1'b1;
          rp_data    <= pack_chr(CH_A);
          rp_len     <= LEN_W'(2);
          rp_load    <= 1'b1;
          state      <= ST_REPLY;
        end
        ST_WAIT: if (gen_done || (rx_valid && rx_data == CH_D)) begin
          gen_enable <= 1'b0;
          gen_rearm  <= 1'b1;
          rp_data    <= pack_chr(CH_T);
          rp_len     <= LEN_W'(2);
          rp_load    <= 1'b1;
          state      <= ST_REPLY;
        end
        default: if (!rp_load && !rp_busy) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       gen_enable,
  input logic       gen_rearm,
  input logic       target_run
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10

  AST_REARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gen_rearm |=> !gen_rearm); // R4

  AST_REARM_STOPS_GEN: assert property (@(posedge clk) disable iff (rst)
    gen_rearm |-> !gen_enable); // R4

  AST_ENABLE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(gen_enable) |-> target_run); // R3
endmodule

bind pulse_cmd_decoder pcd_checker u_pcd_checker (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .gen_enable(gen_enable), .gen_rearm(gen_rearm), .target_run(target_run)
);

// File: tb/pulse_cmd_decoder_test.sv
module pulse_cmd_decoder_test;
  localparam int SETTLE = 40;
  localparam int TOUT   = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic [31:0] gen_edges, gen_offset, gen_width;
  logic        gen_enable, gen_rearm;
  logic        gen_done = 1'b0;
  logic        target_run;
  logic [31:0] io_state = 32'hCAFE_0142;

  int total = 0;
  int bad = 0;
  int rq_n = 0;
  int rearm_cnt = 0;
  logic [7:0] rq [0:63];
  logic [31:0] m_edges = 32'd1, m_ofs = 32'd0, m_wid = 32'd0;

  always #4 clk = ~clk;

  pulse_cmd_decoder #(.SETTLE_CYCLES(SETTLE), .BYTE_TIMEOUT(TOUT)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .gen_edges(gen_edges), .gen_offset(gen_offset), .gen_width(gen_width),
    .gen_enable(gen_enable), .gen_rearm(gen_rearm), .gen_done(gen_done),
    .target_run(target_run), .io_state(io_state)
  );

  always @(negedge clk) begin
    if (tx_valid && tx_ready && rq_n < 64) begin
      rq[rq_n] = tx_data;
      rq_n = rq_n + 1;
    end
    if (gen_rearm) rearm_cnt = rearm_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] v);
    for (int i = 0; i < 4; i++) send_byte(v[8*i +: 8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_reply(input int n);
    for (int i = 0; i < 300 && rq_n < n; i++) @(posedge clk);
    idle(6);
  endtask

  task automatic expect_reply(input string tag, input int n, input logic [103:0] exp);
    wait_reply(n);
    chk(rq_n == n, {tag, " reply length"}, rq_n, n);
    for (int i = 0; i < n && i < rq_n; i++)
      chk(rq[i] == exp[8*i +: 8], {tag, " reply byte"}, rq[i], exp[8*i +: 8]);
    rq_n = 0;
  endtask

  task automatic t_reset;
    chk(target_run == 1'b0, "R8 target_run after reset", target_run, 0);
    chk(gen_enable == 1'b0, "R8 gen_enable after reset", gen_enable, 0);
    chk(tx_valid == 1'b0, "R8 tx_valid after reset", tx_valid, 0);
    send_byte(8'h53);
    expect_reply("R2 R6 status after reset", 13, {8'h0A, 32'd1, 32'd0, 32'd0});
  endtask

  task automatic t_params;
    send_byte(8'h45); send_word(32'h1122_3344); m_edges = 32'h1122_3344;
    expect_reply("R1 edge echo", 5, {64'h0, 8'h0A, 32'h1122_3344});
    send_byte(8'h4F); send_word(32'h0000_0123); m_ofs = 32'h0000_0123;
    expect_reply("R1 offset echo", 5, {64'h0, 8'h0A, 32'h0000_0123});
    send_byte(8'h57); send_word(32'hA5B6_C7D8); m_wid = 32'hA5B6_C7D8;
    expect_reply("R1 width echo", 5, {64'h0, 8'h0A, 32'hA5B6_C7D8});
    send_byte(8'h53);
    expect_reply("R6 status", 13, {8'h0A, m_edges, m_wid, m_ofs});
  endtask

  task automatic t_pin;
    send_byte(8'h47); send_byte(8'h07); send_byte(8'h01);
    expect_reply("R5 pin7 set", 2, {88'h0, 8'h0A, 8'h47});
    chk(target_run == 1'b1, "R5 pin7 nonzero drives 1", target_run, 1);
    send_byte(8'h47); send_byte(8'h05); send_byte(8'h00);
    expect_reply("R5 other pin", 2, {88'h0, 8'h0A, 8'h47});
    chk(target_run == 1'b1, "R5 other pin ignored", target_run, 1);
    send_byte(8'h47); send_byte(8'h07); send_byte(8'h00);
    expect_reply("R5 pin7 clear", 2, {88'h0, 8'h0A, 8'h47});
    chk(target_run == 1'b0, "R5 pin7 zero drives 0", target_run, 0);
  endtask

  task automatic t_unknown_and_read;
    send_byte(8'h5A); idle(10);
    chk(rq_n == 0, "R8 unknown byte no reply", rq_n, 0);
    send_byte(8'h52);
    expect_reply("R7 io snapshot", 5, {64'h0, 8'h0A, 32'hCAFE_0142});
  endtask

  task automatic t_timeout;
    send_byte(8'h4F); send_byte(8'h99); send_byte(8'h88);
    idle(2 * TOUT + 4);
    chk(rq_n == 0, "R9 timeout no reply", rq_n, 0);
    send_byte(8'h53);
    expect_reply("R9 offset kept after timeout", 13, {8'h0A, m_edges, m_wid, m_ofs});
    send_byte(8'h57);
    for (int i = 0; i < 4; i++) begin
      idle(TOUT / 2);
      send_byte(8'h10 + 8'(i));
    end
    m_wid = 32'h1312_1110;
    expect_reply("R9 slow operand accepted", 5, {64'h0, 8'h0A, 32'h1312_1110});
  endtask

  task automatic t_arm;
    int k;
    send_byte(8'h41);
    chk(target_run == 1'b1, "R3 target released", target_run, 1);
    chk(gen_edges == m_edges, "R3 gen_edges", gen_edges, m_edges);
    chk(gen_offset == m_ofs, "R3 gen_offset", gen_offset, m_ofs);
    chk(gen_width == m_wid, "R3 gen_width", gen_width, m_wid);
    k = 0;
    for (int i = 0; i < 4 * SETTLE; i++) begin
      @(negedge clk);
      if (gen_enable) break;
      k++;
    end
    chk(k == SETTLE, "R3 settle interval", k, SETTLE);
    expect_reply("R3 arm reply", 2, {88'h0, 8'h0A, 8'h41});
  endtask

  task automatic t_wait_done;
    int r0;
    r0 = rearm_cnt;
    send_byte(8'h42); idle(20);
    send_byte(8'h58); idle(5);
    chk(rq_n == 0, "R4 wait holds, other byte ignored", rq_n, 0);
    chk(gen_enable == 1'b1, "R4 still enabled while waiting", gen_enable, 1);
    @(posedge clk); #1 gen_done = 1'b1;
    expect_reply("R4 done reply", 2, {88'h0, 8'h0A, 8'h54});
    gen_done = 1'b0;
    chk(gen_enable == 1'b0, "R4 disabled after done", gen_enable, 0);
    chk(rearm_cnt == r0 + 1, "R4 single rearm pulse", rearm_cnt, r0 + 1);
  endtask

  task automatic t_wait_abort;
    int r0;
    send_byte(8'h41);
    expect_reply("R3 second arm reply", 2, {88'h0, 8'h0A, 8'h41});
    r0 = rearm_cnt;
    send_byte(8'h42); idle(10);
    send_byte(8'h44);
    expect_reply("R4 abort reply", 2, {88'h0, 8'h0A, 8'h54});
    chk(gen_enable == 1'b0, "R4 disabled after abort", gen_enable, 0);
    chk(rearm_cnt == r0 + 1, "R4 rearm on abort", rearm_cnt, r0 + 1);
  endtask

  task automatic t_backpressure;
    send_byte(8'h53);
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      tx_ready = (i % 3 == 0);
    end
    tx_ready = 1'b1;
    expect_reply("R10 status under backpressure", 13, {8'h0A, m_edges, m_wid, m_ofs});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    t_reset();
    t_params();
    t_pin();
    t_unknown_and_read();
    t_timeout();
    t_arm();
    t_wait_done();
    t_wait_abort();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule